// File: doc/BRIEF.md
# Host Command Vector Register

This block is a 32-bit register that an external host writes to ask the local processor core to run a chosen exception handler. The host places a vector number in the low byte and sets the command-request bit in the same write or a later one. While the request bit is set, a pending flag goes to the core's status logic. The core answers by pulsing an acknowledge when it fetches the second vector location of the command exception. That pulse clears the request. The host cannot clear the request itself.

While a request is outstanding, the vector field is frozen so that the core always sees a stable handler index. Reserved bits read back as zero and ignore writes. An asynchronous hardware reset and a synchronous software reset both bring the register to its default: request clear and vector set to a fixed index. The host read path is combinational from the registered state.

Top module: `hostcmd_vec_reg`

## Requirements
- R1: A host write (`wr_en`=1) with bit 15 of `wr_data` at 1 sets the request bit. The request bit reads back at `rd_data[15]` after the clock edge of that write, provided no acknowledge or software reset occurs in the same cycle.
- R2: `cmd_pend` equals the request bit at all times, so it rises and falls in the same cycle as `rd_data[15]`.
- R3: An `ack` pulse clears the request bit at the clock edge where `ack` is high, so `cmd_pend` is low in the following cycle.
- R4: Bits 8 to 14 and 16 to 31 of `rd_data` always read as zero. Ones written to those positions have no effect.
- R5: Asserting `rst_n`=0, or asserting `sw_rst`=1 at a clock edge, clears the request bit and loads the vector field with `VEC_RST` (default 0x24). At that edge `sw_rst` overrides any write or acknowledge.
- R6: The vector field is bits 0 to 7 and is presented on `vec_idx`. A host write loads it only while the request bit is clear. While the request bit is set, vector writes are ignored.
- R7: A host write with bit 15 at 0 leaves the request bit unchanged, whether it was set or clear.
- R8: If a host set and an `ack` occur at the same clock edge, the request bit ends clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| sw_rst | input | 1 | Synchronous software reset, active high |
| wr_en | input | 1 | Host write strobe for one cycle |
| wr_data | input | 32 | Host write data |
| rd_data | output | 32 | Host read data: request at bit 15, vector at bits 7:0, zeros elsewhere |
| ack | input | 1 | Core acknowledge on the second vector fetch |
| cmd_pend | output | 1 | Command-pending flag to the core status register |
| vec_idx | output | 8 | Exception vector index presented to the core |

## Verification
Every result of a write, an acknowledge or a software reset comes from one register stage, so it is due in the cycle after the edge that captured the stimulus. `rd_data` and `cmd_pend` are combinational views of that state and carry no extra delay. The bench drives each stimulus on a falling edge and holds it across exactly one rising edge. It removes the stimulus and samples all outputs at the next falling edge, which is the first point where the new value is due. For the cases where something must be ignored, the bench reads the whole register back in that same window. This shows that the vector field, the request bit and the reserved bits did not move.

// File: rtl/hcv_pkg.sv
package hcv_pkg;

    // Per-cycle events seen by the register bits
    typedef struct packed {
        logic wr;    // host write strobe
        logic set;   // host write carries a 1 in the request position
        logic ack;   // core acknowledge of the vector fetch
        logic srst;  // synchronous software reset
    } hcv_evt_t;

endpackage

// File: rtl/hcv_req_ctl.sv
module hcv_req_ctl
    import hcv_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  hcv_evt_t evt,
    output logic     req_q
);

    typedef struct packed {
        logic req;
    } req_st_t;

    req_st_t st_d, st_q;

    // Priority: software reset, then acknowledge clear, then host set.
    // A host 0 never clears.
    always_comb begin
        st_d = st_q;
        if (evt.srst) begin
            st_d.req = 1'b0;
        end else if (evt.ack) begin
            st_d.req = 1'b0;
        end else if (evt.wr && evt.set) begin
            st_d.req = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_q = st_q.req;

    AST_HOST_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (evt.wr && evt.set && !evt.ack && !evt.srst) |=> req_q); // R1

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        evt.ack |=> !req_q); // R3

    AST_ACK_BEATS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (evt.ack && evt.wr && evt.set) |=> !req_q); // R8

    AST_NO_HOST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && !evt.ack && !evt.srst) |=> req_q); // R7

    AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        evt.srst |=> !req_q); // R5

endmodule

// File: rtl/hcv_vec_field.sv
module hcv_vec_field
    import hcv_pkg::*;
#(
    parameter int               VEC_W   = 8,
    parameter logic [VEC_W-1:0] VEC_RST = 8'h24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  hcv_evt_t         evt,
    input  logic [VEC_W-1:0] wr_vec,
    input  logic             locked,
    output logic [VEC_W-1:0] vec_q
);

    typedef struct packed {
        logic [VEC_W-1:0] vec;
    } vec_st_t;

    vec_st_t st_d, st_q;

    // The field is frozen while a request is outstanding
    always_comb begin
        st_d = st_q;
        if (evt.srst) begin
            st_d.vec = VEC_RST;
        end else if (evt.wr && !locked) begin
            st_d.vec = wr_vec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.vec <= VEC_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign vec_q = st_q.vec;

    AST_VEC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !evt.srst) |=> $stable(vec_q)); // R6

    AST_VEC_RST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        evt.srst |=> (vec_q == VEC_RST)); // R5

endmodule

// File: rtl/hostcmd_vec_reg.sv
module hostcmd_vec_reg
    import hcv_pkg::*;
#(
    parameter int               DATA_W  = 32,
    parameter int               VEC_W   = 8,
    parameter int               CMD_BIT = 15,
    parameter logic [VEC_W-1:0] VEC_RST = 8'h24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ack,
    output logic              cmd_pend,
    output logic [VEC_W-1:0]  vec_idx
);

    localparam logic [DATA_W-1:0] LIVE_MASK =
        (DATA_W'(1) << CMD_BIT) | ((DATA_W'(1) << VEC_W) - DATA_W'(1));

    hcv_evt_t         evt;
    logic             req_q;
    logic [VEC_W-1:0] vec_q;

    always_comb begin
        evt.wr   = wr_en;
        evt.set  = wr_data[CMD_BIT];
        evt.ack  = ack;
        evt.srst = sw_rst;
    end

    hcv_req_ctl u_req (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt),
        .req_q (req_q)
    );

    hcv_vec_field #(
        .VEC_W   (VEC_W),
        .VEC_RST (VEC_RST)
    ) u_vec (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt),
        .wr_vec (wr_data[VEC_W-1:0]),
        .locked (req_q),
        .vec_q  (vec_q)
    );

    // Read view: reserved positions are tied to zero
    always_comb begin
        rd_data              = '0;
        rd_data[VEC_W-1:0]   = vec_q;
        rd_data[CMD_BIT]     = req_q;
    end

    assign cmd_pend = req_q;
    assign vec_idx  = vec_q;

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~LIVE_MASK) == '0); // R4

    AST_PEND_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_pend == rd_data[CMD_BIT]); // R2

endmodule

// File: tb/hostcmd_vec_reg_test.sv
`timescale 1ns/1ps
module hostcmd_vec_reg_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_rst = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        ack = 1'b0;
    logic [31:0] rd_data;
    logic        cmd_pend;
    logic [7:0]  vec_idx;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    hostcmd_vec_reg uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_rst   (sw_rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .ack      (ack),
        .cmd_pend (cmd_pend),
        .vec_idx  (vec_idx)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    // Apply one cycle of stimulus across a single rising edge, then sample
    task automatic step(input logic w, input logic [31:0] d, input logic a, input logic s);
        @(negedge clk);
        wr_en = w; wr_data = d; ack = a; sw_rst = s;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; ack = 1'b0; sw_rst = 1'b0;
    endtask

    task automatic expect_state(input string tag, input logic [31:0] rd, input logic p, input logic [7:0] v);
        chk({tag, " rd_data"}, rd_data, rd);
        chk({tag, " cmd_pend"}, {31'd0, cmd_pend}, {31'd0, p});
        chk({tag, " vec_idx"}, {24'd0, vec_idx}, {24'd0, v});
    endtask

    task automatic t_reset_state;
        expect_state("R5 reset", 32'h0000_0024, 1'b0, 8'h24);
    endtask

    task automatic t_vec_write_reserved;
        step(1'b1, 32'hFFFF_7F5A, 1'b0, 1'b0);
        expect_state("R4 R6 R7 vec write", 32'h0000_005A, 1'b0, 8'h5A);
    endtask

    task automatic t_set_request;
        step(1'b1, 32'h0000_80C3, 1'b0, 1'b0);
        expect_state("R1 R2 set", 32'h0000_80C3, 1'b1, 8'hC3);
    endtask

    task automatic t_hold_while_pending;
        step(1'b1, 32'h0000_0011, 1'b0, 1'b0);
        expect_state("R6 R7 hold", 32'h0000_80C3, 1'b1, 8'hC3);
        step(1'b1, 32'hFFFF_FFEE, 1'b0, 1'b0);
        expect_state("R4 R6 hold set", 32'h0000_80C3, 1'b1, 8'hC3);
    endtask

    task automatic t_ack_clear;
        step(1'b0, 32'h0, 1'b1, 1'b0);
        expect_state("R3 R2 ack", 32'h0000_00C3, 1'b0, 8'hC3);
    endtask

    task automatic t_collision;
        step(1'b1, 32'h0000_8077, 1'b1, 1'b0);
        expect_state("R8 collide idle", 32'h0000_0077, 1'b0, 8'h77);
        step(1'b1, 32'h0000_8099, 1'b0, 1'b0);
        expect_state("R1 reset before collide", 32'h0000_8099, 1'b1, 8'h99);
        step(1'b1, 32'h0000_8011, 1'b1, 1'b0);
        expect_state("R8 R6 collide pending", 32'h0000_0099, 1'b0, 8'h99);
    endtask

    task automatic t_idle_ack;
        step(1'b0, 32'h0, 1'b1, 1'b0);
        expect_state("R3 idle ack", 32'h0000_0099, 1'b0, 8'h99);
    endtask

    task automatic t_soft_reset;
        step(1'b1, 32'h0000_8042, 1'b0, 1'b0);
        expect_state("R1 before srst", 32'h0000_8042, 1'b1, 8'h42);
        step(1'b1, 32'h0000_80AA, 1'b0, 1'b1);
        expect_state("R5 soft reset", 32'h0000_0024, 1'b0, 8'h24);
    endtask

    task automatic t_hw_reset;
        step(1'b1, 32'h0000_8033, 1'b0, 1'b0);
        expect_state("R1 before hw rst", 32'h0000_8033, 1'b1, 8'h33);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        expect_state("R5 hw reset", 32'h0000_0024, 1'b0, 8'h24);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_vec_write_reserved();
        t_set_request();
        t_hold_while_pending();
        t_ack_clear();
        t_collision();
        t_idle_ack();
        t_soft_reset();
        t_hw_reset();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule